// File: doc/BRIEF.md
# Parallel Camera Bus Capture with Colour-Phase Tagging

This block sits directly behind the pins of a parallel image sensor. It samples a 12-bit pixel bus together with a frame-valid and a line-valid qualifier on the falling edge of the pixel clock. It turns what it samples into a stream of output beats. Each beat carries the pixel value, its row and column inside the frame and one of four Bayer colour codes. Green pixels that share a row with red and green pixels that share a row with blue are reported as two separate codes. The first pixel of a frame carries a start-of-frame flag, and the last pixel of each line carries an end-of-line flag. The stream has no back-pressure: a beat is present for exactly one clock when `px_valid` is high.

Frame-valid stays high across horizontal blanking and drops only in vertical blanking. Line-valid is high only while real pixels are on the bus. Two static mirror inputs shift the colour phase when the sensor reads out flipped, horizontally, vertically or both. Line-valid asserted outside a frame is a protocol violation. Each such sample raises a one-clock error pulse, and the pixel is thrown away. Everything runs on the pixel clock. Moving the stream into another clock domain is the consumer's job.

Top module: `pbus_bayer_capture`

## Requirements
- R1: Bus data, frame-valid and line-valid are sampled on the falling pixel-clock edge, and an accepted pixel's 12 bits appear unchanged on `px_data`.
- R2: The column of a pixel is 0 for the first sample of a line (line-valid rising while frame-valid is high) and rises by one for each further accepted pixel of that line.
- R3: The row is 0 for lines after frame-valid rises and rises by one each time an accepted line ends (line-valid falling, or frame-valid falling during a line).
- R4: With both mirror inputs low, `px_color` is {row[0], col[0]}: 0 = green-on-red-row (even row, even column), 1 = red, 2 = blue, 3 = green-on-blue-row.
- R5: `mirror_h` high inverts the column parity used for the colour code.
- R6: `mirror_v` high inverts the row parity used for the colour code.
- R7: `px_sof` is high on the first accepted pixel after frame-valid rises and on no other pixel.
- R8: `px_eol` is high on the last pixel of every line, including a one-pixel line, and on no other pixel.
- R9: Each sample with line-valid high and frame-valid low gives one `proto_err` pulse and produces no output beat. It has no effect on the numbering of the next frame.
- R10: While reset is high, `px_valid` and `proto_err` are low.
- R11: Every accepted pixel produces exactly one output beat, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock from the sensor |
| rst | input | 1 | Synchronous active-high reset |
| mirror_h | input | 1 | Readout is mirrored left-right |
| mirror_v | input | 1 | Readout is mirrored top-bottom |
| bus_data | input | 12 | Pixel data, MSB on bit 11 |
| bus_fv | input | 1 | Frame-valid qualifier |
| bus_lv | input | 1 | Line-valid qualifier |
| px_valid | output | 1 | Output beat present |
| px_data | output | 12 | Pixel value |
| px_row | output | 12 | Row index within the frame |
| px_col | output | 12 | Column index within the line |
| px_color | output | 2 | Bayer colour code |
| px_sof | output | 1 | First pixel of the frame |
| px_eol | output | 1 | Last pixel of the line |
| proto_err | output | 1 | Line-valid seen outside a frame |

## Verification
The hardest cases to reach are the ones where several edges meet in one sample. One is a frame whose first pixel arrives in the same sample that frame-valid rises. Another is a line only one pixel long, where that pixel must be flagged both as the start of the frame and as the end of its line. A third is a burst of line-valid while frame-valid is low, followed at once by a clean frame. The driver task builds each of these on purpose: it can raise both qualifiers together, it accepts a line length of one, and it drives an error burst right before a normal frame. The mirror inputs are changed between frames so that all four colour phases are exercised.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    CLR_GR = 2'd0,
    CLR_R  = 2'd1,
    CLR_B  = 2'd2,
    CLR_GB = 2'd3
  } bayer_e;

  // Colour code from row and column parity after mirror correction.
  function automatic bayer_e bayer_of(input logic row_par, input logic col_par);
    return bayer_e'({row_par, col_par});
  endfunction
endpackage

// File: rtl/pbus_sampler.sv
module pbus_sampler #(
  parameter int DATA_W = 12
) (
  input  logic              pclk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_fv,
  input  logic              bus_lv,
  output logic [DATA_W-1:0] s_data,
  output logic              s_fv,
  output logic              s_lv
);
  // The sensor launches on the rising edge, so capture on the falling edge.
  always_ff @(negedge pclk) begin
    if (rst) begin
      s_data <= '0;
      s_fv   <= 1'b0;
      s_lv   <= 1'b0;
    end else begin
      s_data <= bus_data;
      s_fv   <= bus_fv;
      s_lv   <= bus_lv;
    end
  end
endmodule

// File: rtl/pbus_framer.sv
module pbus_framer #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12
) (
  input  logic             pclk,
  input  logic             rst,
  input  logic             s_fv,
  input  logic             s_lv,
  output logic             take,
  output logic             line_end,
  output logic             proto,
  output logic             first,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col
);
  logic             fv_q;
  logic             line_q;
  logic             sof_pend;
  logic [ROW_W-1:0] row_cnt;
  logic [COL_W-1:0] col_cnt;
  logic             lv_ok;
  logic             line_rise;
  logic             fv_rise;

  always_comb begin
    lv_ok     = s_fv & s_lv;
    line_rise = lv_ok & ~line_q;
    fv_rise   = s_fv & ~fv_q;
    take      = lv_ok;
    line_end  = ~lv_ok & line_q;
    proto     = s_lv & ~s_fv;
    cur_col   = line_rise ? '0 : col_cnt;
    cur_row   = fv_rise ? '0 : row_cnt;
    first     = lv_ok & (fv_rise | sof_pend);
  end

  always_ff @(posedge pclk) begin
    if (rst) begin
      fv_q     <= 1'b0;
      line_q   <= 1'b0;
      sof_pend <= 1'b0;
      row_cnt  <= '0;
      col_cnt  <= '0;
    end else begin
      fv_q   <= s_fv;
      line_q <= lv_ok;
      if (take)
        col_cnt <= cur_col + 1'b1;
      if (line_end)
        row_cnt <= row_cnt + 1'b1;
      else if (fv_rise)
        row_cnt <= '0;
      if (take)
        sof_pend <= 1'b0;
      else if (fv_rise)
        sof_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pbus_tagger.sv
module pbus_tagger
  import pbus_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12
) (
  input  logic              pclk,
  input  logic              rst,
  input  logic              take,
  input  logic              line_end,
  input  logic              proto,
  input  logic              first,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic [COL_W-1:0]  cur_col,
  input  logic [DATA_W-1:0] s_data,
  input  logic              mirror_h,
  input  logic              mirror_v,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [1:0]        out_color,
  output logic              out_sof,
  output logic              out_eol,
  output logic              out_err
);
  // One-pixel holding stage: a pixel leaves only when its successor
  // (or the end of its line) is known, so end-of-line can be tagged.
  logic              hold_v;
  logic [DATA_W-1:0] hold_data;
  logic [ROW_W-1:0]  hold_row;
  logic [COL_W-1:0]  hold_col;
  bayer_e            hold_color;
  logic              hold_sof;
  logic              emit;

  assign emit = hold_v & (take | line_end);

  always_ff @(posedge pclk) begin
    if (rst) begin
      hold_v     <= 1'b0;
      hold_data  <= '0;
      hold_row   <= '0;
      hold_col   <= '0;
      hold_color <= CLR_GR;
      hold_sof   <= 1'b0;
    end else if (take) begin
      hold_v     <= 1'b1;
      hold_data  <= s_data;
      hold_row   <= cur_row;
      hold_col   <= cur_col;
      hold_color <= bayer_of(cur_row[0] ^ mirror_v, cur_col[0] ^ mirror_h);
      hold_sof   <= first;
    end else if (line_end) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge pclk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_color <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= emit;
      out_err   <= proto;
      if (emit) begin
        out_data  <= hold_data;
        out_row   <= hold_row;
        out_col   <= hold_col;
        out_color <= logic'(hold_color[1]) ? {1'b1, hold_color[0]} : {1'b0, hold_color[0]};
        out_sof   <= hold_sof;
        out_eol   <= line_end;
      end
    end
  end

  // R7: a frame always starts at row 0, column 0
  a_r7_sof_origin: assert property (@(posedge pclk) disable iff (rst)
    (out_valid && out_sof) |-> (out_row == '0 && out_col == '0));

  // R8: after the end of a line nothing is emitted in the next cycle
  a_r8_eol_gap: assert property (@(posedge pclk) disable iff (rst)
    (out_valid && out_eol) |=> !out_valid);

  // R2: inside a line, beats are back to back with consecutive columns
  a_r2_col_step: assert property (@(posedge pclk) disable iff (rst)
    (out_valid && !out_eol) |=> (out_valid && out_col == $past(out_col) + 1'b1));

  // R3: the row stays constant within a line
  a_r3_row_hold: assert property (@(posedge pclk) disable iff (rst)
    (out_valid && !out_eol) |=> (out_row == $past(out_row)));
endmodule

// File: rtl/pbus_bayer_capture.sv
module pbus_bayer_capture #(
  parameter int DATA_W = 12,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12
) (
  input  logic              pclk,
  input  logic              rst,
  input  logic              mirror_h,
  input  logic              mirror_v,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_fv,
  input  logic              bus_lv,
  output logic              px_valid,
  output logic [DATA_W-1:0] px_data,
  output logic [ROW_W-1:0]  px_row,
  output logic [COL_W-1:0]  px_col,
  output logic [1:0]        px_color,
  output logic              px_sof,
  output logic              px_eol,
  output logic              proto_err
);
  logic [DATA_W-1:0] s_data;
  logic              s_fv;
  logic              s_lv;
  logic              take;
  logic              line_end;
  logic              proto;
  logic              first;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;

  pbus_sampler #(.DATA_W(DATA_W)) u_sampler (
    .pclk(pclk), .rst(rst),
    .bus_data(bus_data), .bus_fv(bus_fv), .bus_lv(bus_lv),
    .s_data(s_data), .s_fv(s_fv), .s_lv(s_lv)
  );

  pbus_framer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_framer (
    .pclk(pclk), .rst(rst),
    .s_fv(s_fv), .s_lv(s_lv),
    .take(take), .line_end(line_end), .proto(proto), .first(first),
    .cur_row(cur_row), .cur_col(cur_col)
  );

  pbus_tagger #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_tagger (
    .pclk(pclk), .rst(rst),
    .take(take), .line_end(line_end), .proto(proto), .first(first),
    .cur_row(cur_row), .cur_col(cur_col), .s_data(s_data),
    .mirror_h(mirror_h), .mirror_v(mirror_v),
    .out_valid(px_valid), .out_data(px_data), .out_row(px_row),
    .out_col(px_col), .out_color(px_color), .out_sof(px_sof),
    .out_eol(px_eol), .out_err(proto_err)
  );
endmodule

// File: tb/pbus_bayer_capture_test.sv
module pbus_bayer_capture_test;
  typedef struct packed {
    logic [11:0] d;
    logic [11:0] r;
    logic [11:0] c;
    logic [1:0]  clr;
    logic        sof;
    logic        eol;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mirror_h = 1'b0;
  logic        mirror_v = 1'b0;
  logic [11:0] bus_data = '0;
  logic        bus_fv = 1'b0;
  logic        bus_lv = 1'b0;
  logic        px_valid;
  logic [11:0] px_data;
  logic [11:0] px_row;
  logic [11:0] px_col;
  logic [1:0]  px_color;
  logic        px_sof;
  logic        px_eol;
  logic        proto_err;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  logic [11:0] dval = 12'h5a1;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pbus_bayer_capture uut (
    .pclk(clk), .rst(rst), .mirror_h(mirror_h), .mirror_v(mirror_v),
    .bus_data(bus_data), .bus_fv(bus_fv), .bus_lv(bus_lv),
    .px_valid(px_valid), .px_data(px_data), .px_row(px_row),
    .px_col(px_col), .px_color(px_color), .px_sof(px_sof),
    .px_eol(px_eol), .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Driver: one frame, pushes the expected beats into the scoreboard.
  task automatic drive_frame(input int nrows, input int ncols, input bit mh,
                             input bit mv, input int gap, input bit overlap);
    exp_t e;
    mirror_h = mh;
    mirror_v = mv;
    bus_fv = 1'b1;
    if (!overlap) begin
      step();
      step();
    end
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < ncols; c++) begin
        bus_lv   = 1'b1;
        bus_data = dval;
        e.d   = dval;
        e.r   = 12'(r);
        e.c   = 12'(c);
        e.clr = {1'(r % 2) ^ mv, 1'(c % 2) ^ mh};
        e.sof = (r == 0 && c == 0);
        e.eol = (c == ncols - 1);
        exp_q.push_back(e);
        dval = dval * 12'd5 + 12'h9a3;
        step();
      end
      bus_lv   = 1'b0;
      bus_data = 12'hfff;
      for (int g = 0; g < gap; g++) step();
    end
    bus_fv = 1'b0;
    for (int g = 0; g < 4; g++) step();
  endtask

  // Monitor: compares each beat with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (proto_err) err_seen++;
      if (px_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected beat (R9 dropped pixel leaked)", int'(px_data), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(px_data == e.d, "R1 data", int'(px_data), int'(e.d));
          check(px_col == e.c, "R2 column", int'(px_col), int'(e.c));
          check(px_row == e.r, "R3 row", int'(px_row), int'(e.r));
          check(px_color == e.clr, "R4 R5 R6 colour", int'(px_color), int'(e.clr));
          check(px_sof == e.sof, "R7 sof", int'(px_sof), int'(e.sof));
          check(px_eol == e.eol, "R8 eol", int'(px_eol), int'(e.eol));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bus_lv = 1'b1;
    bus_fv = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(px_valid == 1'b0, "R10 valid low in reset", int'(px_valid), 0);
      check(proto_err == 1'b0, "R10 err low in reset", int'(proto_err), 0);
    end
    bus_lv = 1'b0;
    bus_fv = 1'b0;
    step();
    rst = 1'b0;
    for (int i = 0; i < 3; i++) step();

    drive_frame(3, 5, 1'b0, 1'b0, 2, 1'b0);   // R4 plain phase
    drive_frame(2, 4, 1'b1, 1'b0, 1, 1'b0);   // R5 horizontal mirror
    drive_frame(3, 3, 1'b0, 1'b1, 3, 1'b1);   // R6 vertical mirror, first pixel with frame start
    drive_frame(2, 1, 1'b1, 1'b1, 2, 1'b0);   // R8 one-pixel lines, both mirrors

    // R9: line-valid outside a frame, then a clean frame
    bus_lv = 1'b1;
    bus_data = 12'h777;
    for (int i = 0; i < 3; i++) step();
    bus_lv = 1'b0;
    for (int i = 0; i < 3; i++) step();
    check(err_seen == 3, "R9 error pulses", err_seen, 3);
    drive_frame(2, 6, 1'b0, 1'b0, 2, 1'b1);

    for (int i = 0; i < 10; i++) step();
    check(exp_q.size() == 0, "R11 all beats delivered", exp_q.size(), 0);
    check(err_seen == 3, "R9 no spurious errors", err_seen, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule